// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block runs single read and write cycles to an asynchronous memory or memory-mapped peripheral on behalf of a host. The host raises a request with a direction, a chip-select index, a word address, a bank address, byte enables and write data. It holds these values until a one-cycle acknowledge comes back. For reads, the captured data is returned with that acknowledge.

Every access has three phases, counted in interface clock cycles. In the setup phase the selected chip select is low and the address, bank and byte enables are stable. In the strobe phase output-enable (for reads) or write-enable (for writes) is low. In the hold phase the strobe has returned high but the selects are still driven. Each chip select has its own configuration word. That word holds a setup, strobe and hold length for reads and a separate set of three for writes. An optional ready input, whose active level can be chosen, can stretch the strobe phase. All memory-side outputs are registered.

Top module: `amem_ctrl`

## Requirements
- R1: After reset every chip-select line is high, output-enable and write-enable are high, the read/write indicator is high (read), write-data drive is off and the acknowledge is low.
- R2: On a read, the chip select stays low for setup+strobe+hold cycles. Output-enable stays high for the first setup cycles, then goes low for exactly the strobe cycles, then stays high for the hold cycles. The lengths come from the read fields of the selected chip select's configuration.
- R3: On a write, the same three-phase sequence runs on write-enable using the write fields. The read/write indicator is low, the write-data drive enable is high and the write data equals the request data for the whole chip-select-low window. Output-enable never goes low.
- R4: The configuration port packs one 24-bit word per chip select, with chip select n at bits [24n+23:24n]. Inside each word, in 4-bit fields from the LSB up, come read setup, read strobe, read hold, write setup, write strobe and write hold. Only the addressed chip-select line goes low during an access.
- R5: A setup, strobe or hold field of 0 behaves as a length of 1 cycle.
- R6: When ready checking is enabled, the ready input is sampled in the last programmed strobe cycle and in each extra cycle after it. The strobe phase continues while the sampled level differs from the polarity input, which is 1 for active-high and 0 for active-low.
- R7: When ready checking is disabled, the ready input has no effect on strobe length.
- R8: Read data is taken from the memory data input in the final strobe cycle. It is presented on the host data output with a single-cycle acknowledge in the cycle after the last hold cycle, when the chip select has already returned high. A request still held during that acknowledge cycle does not start a new access.
- R9: The address, bank address and active-low byte enables (the inverse of the request byte enables) hold their values for the whole chip-select-low window.
- R10: Output-enable and write-enable are never low together, and neither is low unless a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Active-low reset |
| cfg_i | input | NUM_CS*24 | Per-chip-select timing words |
| rdy_use_i | input | 1 | Enable ready-based strobe extension |
| rdy_pol_i | input | 1 | Active level of the ready input |
| req_i | input | 1 | Host request, held until acknowledge |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_cs_i | input | CS_W | Chip-select index |
| req_addr_i | input | ADDR_W | Word address |
| req_bank_i | input | BANK_W | Bank address |
| req_be_i | input | DATA_W/8 | Byte enables, active high |
| req_wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data, valid with acknowledge |
| mem_ce_n_o | output | NUM_CS | Active-low chip selects |
| mem_be_n_o | output | DATA_W/8 | Active-low byte enables |
| mem_addr_o | output | ADDR_W | Word address to memory |
| mem_bank_o | output | BANK_W | Bank address to memory |
| mem_rnw_o | output | 1 | High for read, low for write |
| mem_oe_n_o | output | 1 | Active-low output-enable |
| mem_we_n_o | output | 1 | Active-low write-enable |
| mem_dout_o | output | DATA_W | Write data to memory |
| mem_dout_en_o | output | 1 | Write-data drive enable |
| mem_din_i | input | DATA_W | Read data from memory |
| mem_rdy_i | input | 1 | Ready from memory |

## Verification
The main check sweeps every combination of setup, strobe and hold from 0 to 3 for both reads and writes, rotating across all four chip selects. The other chip selects' words are loaded with all-ones fields, so reading the wrong word or the wrong direction's fields shows up as a wrong phase length. The memory data input changes every cycle, so a capture one cycle early or late gives the wrong read data. Ready is then released after 0 to 6 strobe cycles under both polarities, which separates a stretch from a sample taken at the wrong time or with the wrong level. A final run holds ready inactive with checking disabled, to show that the input is then ignored.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int unsigned AMEM_PH_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } amem_state_e;

    // one chip select's timing word; first member is the MSB
    typedef struct packed {
        logic [AMEM_PH_W-1:0] wr_hold;
        logic [AMEM_PH_W-1:0] wr_strobe;
        logic [AMEM_PH_W-1:0] wr_setup;
        logic [AMEM_PH_W-1:0] rd_hold;
        logic [AMEM_PH_W-1:0] rd_strobe;
        logic [AMEM_PH_W-1:0] rd_setup;
    } amem_cs_cfg_t;

    // terminal counts (length minus one) for the current access
    typedef struct packed {
        logic [AMEM_PH_W-1:0] setup;
        logic [AMEM_PH_W-1:0] strobe;
        logic [AMEM_PH_W-1:0] hold;
    } amem_timing_t;

    function automatic logic [AMEM_PH_W-1:0] amem_last_cnt(input logic [AMEM_PH_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

endpackage

// File: rtl/amem_cfg_sel.sv
module amem_cfg_sel
    import amem_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CS_W   = 2
) (
    input  logic [NUM_CS*$bits(amem_cs_cfg_t)-1:0] cfg_i,
    input  logic [CS_W-1:0]                        cs_i,
    input  logic                                   we_i,
    output amem_timing_t                           tim_o
);
    localparam int unsigned CFG_W = $bits(amem_cs_cfg_t);

    amem_cs_cfg_t cfg_arr [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign cfg_arr[g] = cfg_i[g*CFG_W +: CFG_W];
    end

    always_comb begin
        amem_cs_cfg_t sel;
        sel = cfg_arr[cs_i];
        if (we_i) begin
            tim_o.setup  = amem_last_cnt(sel.wr_setup);
            tim_o.strobe = amem_last_cnt(sel.wr_strobe);
            tim_o.hold   = amem_last_cnt(sel.wr_hold);
        end else begin
            tim_o.setup  = amem_last_cnt(sel.rd_setup);
            tim_o.strobe = amem_last_cnt(sel.rd_strobe);
            tim_o.hold   = amem_last_cnt(sel.rd_hold);
        end
    end

endmodule

// File: rtl/amem_rdy_qual.sv
module amem_rdy_qual (
    input  logic rdy_i,
    input  logic use_i,
    input  logic pol_i,
    output logic go_o
);
    // strobe may end when checking is off or ready sits at its active level
    assign go_o = !use_i || (rdy_i == pol_i);
endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
    import amem_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned BANK_W = 2,
    localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned BE_W  = DATA_W / 8,
    localparam int unsigned CFG_W = $bits(amem_cs_cfg_t)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NUM_CS*CFG_W-1:0] cfg_i,
    input  logic                    rdy_use_i,
    input  logic                    rdy_pol_i,
    input  logic                    req_i,
    input  logic                    req_we_i,
    input  logic [CS_W-1:0]         req_cs_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic [BANK_W-1:0]       req_bank_i,
    input  logic [BE_W-1:0]         req_be_i,
    input  logic [DATA_W-1:0]       req_wdata_i,
    output logic                    ack_o,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [NUM_CS-1:0]       mem_ce_n_o,
    output logic [BE_W-1:0]         mem_be_n_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic [BANK_W-1:0]       mem_bank_o,
    output logic                    mem_rnw_o,
    output logic                    mem_oe_n_o,
    output logic                    mem_we_n_o,
    output logic [DATA_W-1:0]       mem_dout_o,
    output logic                    mem_dout_en_o,
    input  logic [DATA_W-1:0]       mem_din_i,
    input  logic                    mem_rdy_i
);

    typedef struct packed {
        amem_state_e          st;
        logic [AMEM_PH_W-1:0] cnt;
        logic                 is_wr;
        logic [CS_W-1:0]      cs;
        logic [NUM_CS-1:0]    ce_n;
        logic                 oe_n;
        logic                 we_n;
        logic                 rnw;
        logic                 dout_en;
        logic [BE_W-1:0]      be_n;
        logic [ADDR_W-1:0]    addr;
        logic [BANK_W-1:0]    bank;
        logic [DATA_W-1:0]    wdata;
        logic [DATA_W-1:0]    rdata;
        logic                 ack;
    } ctrl_reg_t;

    ctrl_reg_t    r_d, r_q;
    amem_timing_t tim;
    logic         strobe_go;
    logic         idle;
    logic [CS_W-1:0] sel_cs;
    logic         sel_we;

    assign idle   = (r_q.st == ST_IDLE);
    assign sel_cs = idle ? req_cs_i : r_q.cs;
    assign sel_we = idle ? req_we_i : r_q.is_wr;

    amem_cfg_sel #(
        .NUM_CS (NUM_CS),
        .CS_W   (CS_W)
    ) u_cfg_sel (
        .cfg_i (cfg_i),
        .cs_i  (sel_cs),
        .we_i  (sel_we),
        .tim_o (tim)
    );

    amem_rdy_qual u_rdy_qual (
        .rdy_i (mem_rdy_i),
        .use_i (rdy_use_i),
        .pol_i (rdy_pol_i),
        .go_o  (strobe_go)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i && !r_q.ack) begin
                    r_d.st           = ST_SETUP;
                    r_d.cnt          = tim.setup;
                    r_d.is_wr        = req_we_i;
                    r_d.cs           = req_cs_i;
                    r_d.ce_n         = '1;
                    r_d.ce_n[req_cs_i] = 1'b0;
                    r_d.rnw          = !req_we_i;
                    r_d.dout_en      = req_we_i;
                    r_d.be_n         = ~req_be_i;
                    r_d.addr         = req_addr_i;
                    r_d.bank         = req_bank_i;
                    r_d.wdata        = req_wdata_i;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_STROBE;
                    r_d.cnt = tim.strobe;
                    if (r_q.is_wr) r_d.we_n = 1'b0;
                    else           r_d.oe_n = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (strobe_go) begin
                    r_d.st   = ST_HOLD;
                    r_d.cnt  = tim.hold;
                    r_d.oe_n = 1'b1;
                    r_d.we_n = 1'b1;
                    if (!r_q.is_wr) r_d.rdata = mem_din_i;
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.st      = ST_IDLE;
                    r_d.ce_n    = '1;
                    r_d.rnw     = 1'b1;
                    r_d.dout_en = 1'b0;
                    r_d.ack     = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.ce_n    <= '1;
            r_q.oe_n    <= 1'b1;
            r_q.we_n    <= 1'b1;
            r_q.rnw     <= 1'b1;
            r_q.be_n    <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o         = r_q.ack;
    assign rdata_o       = r_q.rdata;
    assign mem_ce_n_o    = r_q.ce_n;
    assign mem_be_n_o    = r_q.be_n;
    assign mem_addr_o    = r_q.addr;
    assign mem_bank_o    = r_q.bank;
    assign mem_rnw_o     = r_q.rnw;
    assign mem_oe_n_o    = r_q.oe_n;
    assign mem_we_n_o    = r_q.we_n;
    assign mem_dout_o    = r_q.wdata;
    assign mem_dout_en_o = r_q.dout_en;

endmodule

// File: rtl/amem_ctrl_chk.sv
module amem_ctrl_chk #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned BANK_W = 2,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ack_o,
    input logic [NUM_CS-1:0] mem_ce_n_o,
    input logic [BE_W-1:0]   mem_be_n_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [BANK_W-1:0] mem_bank_o,
    input logic              mem_oe_n_o,
    input logic              mem_we_n_o,
    input logic [DATA_W-1:0] mem_dout_o,
    input logic              mem_dout_en_o
);
    logic ce_act;
    assign ce_act = !(&mem_ce_n_o);

    p_one_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~mem_ce_n_o));

    p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!mem_oe_n_o && !mem_we_n_o));

    p_strobe_in_ce_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_oe_n_o || !mem_we_n_o) |-> ce_act);

    p_setup_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ce_act) |-> (mem_oe_n_o && mem_we_n_o));

    p_hold_after_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_oe_n_o) |-> ce_act);

    p_hold_after_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_n_o) |-> ce_act);

    p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    p_ack_after_ce_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (!ce_act && $past(ce_act)));

    p_sel_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_act && $past(ce_act)) |->
        ($stable(mem_addr_o) && $stable(mem_bank_o) && $stable(mem_be_n_o) && $stable(mem_ce_n_o)));

    p_wdata_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_act && $past(ce_act) && mem_dout_en_o) |-> $stable(mem_dout_o));

endmodule

bind amem_ctrl amem_ctrl_chk #(
    .NUM_CS (NUM_CS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ack_o         (ack_o),
    .mem_ce_n_o    (mem_ce_n_o),
    .mem_be_n_o    (mem_be_n_o),
    .mem_addr_o    (mem_addr_o),
    .mem_bank_o    (mem_bank_o),
    .mem_oe_n_o    (mem_oe_n_o),
    .mem_we_n_o    (mem_we_n_o),
    .mem_dout_o    (mem_dout_o),
    .mem_dout_en_o (mem_dout_en_o)
);

// File: tb/amem_ctrl_tb.sv
module amem_ctrl_tb;

    localparam int NCS = 4;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic [NCS*24-1:0] cfg_i = '1;
    logic            rdy_use_i = 1'b0;
    logic            rdy_pol_i = 1'b1;
    logic            req_i = 1'b0;
    logic            req_we_i = 1'b0;
    logic [1:0]      req_cs_i = '0;
    logic [19:0]     req_addr_i = '0;
    logic [1:0]      req_bank_i = '0;
    logic [7:0]      req_be_i = '0;
    logic [63:0]     req_wdata_i = '0;
    logic            ack_o;
    logic [63:0]     rdata_o;
    logic [NCS-1:0]  mem_ce_n_o;
    logic [7:0]      mem_be_n_o;
    logic [19:0]     mem_addr_o;
    logic [1:0]      mem_bank_o;
    logic            mem_rnw_o;
    logic            mem_oe_n_o;
    logic            mem_we_n_o;
    logic [63:0]     mem_dout_o;
    logic            mem_dout_en_o;
    logic [63:0]     mem_din_i = '0;
    logic            mem_rdy_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    int unsigned cyc = 0;

    always #2.5 clk_i = ~clk_i;
    always @(posedge clk_i) cyc <= cyc + 1;

    amem_ctrl u_dut (
        .clk_i, .rst_ni, .cfg_i, .rdy_use_i, .rdy_pol_i,
        .req_i, .req_we_i, .req_cs_i, .req_addr_i, .req_bank_i, .req_be_i, .req_wdata_i,
        .ack_o, .rdata_o, .mem_ce_n_o, .mem_be_n_o, .mem_addr_o, .mem_bank_o,
        .mem_rnw_o, .mem_oe_n_o, .mem_we_n_o, .mem_dout_o, .mem_dout_en_o,
        .mem_din_i, .mem_rdy_i
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // one access; expected phase lengths supplied by the caller
    task automatic run_access(input bit we, input int cs, input int addr, input int bank,
                              input logic [7:0] be, input logic [63:0] wd,
                              input int e_su, input int e_st, input int e_ho,
                              input int rdy_after, input string st_tag);
        int su = 0, st = 0, ho = 0, n = 0;
        bit seen_strobe = 0, done = 0;
        bit bad_cs = 0, bad_sel = 0, bad_excl = 0, bad_dir = 0;
        logic [63:0] last_din = '0;
        string ptag;
        ptag = we ? "R3" : "R2";
        mem_rdy_i   = (rdy_after == 0) ? rdy_pol_i : ~rdy_pol_i;
        mem_din_i   = {cyc, ~cyc};
        req_we_i    = we;
        req_cs_i    = cs[1:0];
        req_addr_i  = addr[19:0];
        req_bank_i  = bank[1:0];
        req_be_i    = be;
        req_wdata_i = wd;
        req_i       = 1'b1;
        while (!done && n < 300) begin
            @(negedge clk_i);
            n++;
            if (ack_o) begin
                done = 1;
            end else if (mem_ce_n_o != '1) begin
                if (mem_ce_n_o != ~(4'b1 << cs)) bad_cs = 1;
                if (mem_addr_o != addr[19:0] || mem_bank_o != bank[1:0] || mem_be_n_o != ~be) bad_sel = 1;
                if (!mem_oe_n_o && !mem_we_n_o) bad_excl = 1;
                if (we) begin
                    if (!mem_oe_n_o || mem_rnw_o || !mem_dout_en_o || mem_dout_o != wd) bad_dir = 1;
                end else begin
                    if (!mem_we_n_o || !mem_rnw_o || mem_dout_en_o) bad_dir = 1;
                end
                mem_din_i = {cyc, ~cyc};
                if ((we && !mem_we_n_o) || (!we && !mem_oe_n_o)) begin
                    st++;
                    seen_strobe = 1;
                    last_din = mem_din_i;
                end else if (!seen_strobe) su++;
                else ho++;
                mem_rdy_i = (st >= rdy_after) ? rdy_pol_i : ~rdy_pol_i;
            end else begin
                if (!mem_oe_n_o || !mem_we_n_o) bad_excl = 1;
                mem_din_i = {cyc, ~cyc};
            end
        end
        if (!done) begin
            fails++;
            $display("FAIL R8 no acknowledge got=0 exp=1");
        end
        chk({ptag, " setup"}, su, e_su);
        chk({st_tag, " strobe"}, st, e_st);
        chk({ptag, " hold"}, ho, e_ho);
        chk("R4 only addressed cs low", bad_cs, 0);
        chk("R9 selects held", bad_sel, 0);
        chk("R10 strobes exclusive", bad_excl, 0);
        chk({ptag, " direction signals"}, bad_dir, 0);
        chk("R8 ce high at ack", mem_ce_n_o, 4'hF);
        if (!we) chk("R8 read data", rdata_o, last_din);
        req_i = 1'b0;
        @(negedge clk_i);
        chk("R8 ack single cycle", ack_o, 0);
        chk("R8 no restart in ack cycle", mem_ce_n_o, 4'hF);
    endtask

    function automatic logic [23:0] pack_cfg(input int rs, input int rst, input int rh,
                                             input int ws, input int wst, input int wh);
        return {wh[3:0], wst[3:0], ws[3:0], rh[3:0], rst[3:0], rs[3:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk_i);
        // R1: reset values
        chk("R1 ce", mem_ce_n_o, 4'hF);
        chk("R1 oe", mem_oe_n_o, 1);
        chk("R1 we", mem_we_n_o, 1);
        chk("R1 ack", ack_o, 0);
        chk("R1 rnw", mem_rnw_o, 1);
        chk("R1 dout_en", mem_dout_en_o, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R2 R3 R4 R5 R9: full sweep over small lengths
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 4; s++) begin
                for (int t = 0; t < 4; t++) begin
                    for (int h = 0; h < 4; h++) begin
                        int cs = idx % NCS;
                        string tg;
                        cfg_i = '1;
                        if (w == 1) cfg_i[cs*24 +: 24] = pack_cfg(15, 15, 15, s, t, h);
                        else        cfg_i[cs*24 +: 24] = pack_cfg(s, t, h, 15, 15, 15);
                        tg = (t == 0) ? "R5" : (w == 1 ? "R3" : "R2");
                        run_access(w[0], cs, idx * 4099 + 7, idx % 4, idx[7:0] ^ 8'h5A,
                                   {idx, ~idx} ^ 64'h0123_4567_89AB_CDEF,
                                   eff(s), eff(t), eff(h), 0, tg);
                        idx++;
                    end
                end
            end
        end

        // R6: ready stretches strobe, both polarities
        rdy_use_i = 1'b1;
        for (int p = 0; p < 2; p++) begin
            rdy_pol_i = p[0];
            for (int ra = 0; ra < 7; ra++) begin
                int cs = (ra + p) % NCS;
                cfg_i = '1;
                cfg_i[cs*24 +: 24] = pack_cfg(1, 2, 1, 2, 2, 2);
                run_access(ra[0], cs, ra * 33, ra % 4, 8'hC3, 64'hFEED_0000 + ra,
                           ra[0] ? 2 : 1, (ra > 2) ? ra : 2, ra[0] ? 2 : 1, ra, "R6");
            end
        end

        // R7: ready ignored when checking is off, even if held inactive
        rdy_use_i = 1'b0;
        for (int p = 0; p < 2; p++) begin
            rdy_pol_i = p[0];
            cfg_i = '1;
            cfg_i[24 +: 24] = pack_cfg(1, 3, 1, 1, 4, 1);
            run_access(p[0], 1, 555, 3, 8'h0F, 64'h1111_2222_3333_4444,
                       1, p[0] ? 4 : 3, 1, 1000, "R7");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule